// File: doc/BRIEF.md
# Rate one-third turbo encoder core

This block produces a rate one-third parallel-concatenated convolutional code, one input bit per clock. Each accepted input word carries a systematic bit together with the matching bit from an interleaver that sits upstream. Two identical 8-state recursive systematic encoders run side by side. The first is fed the systematic bits in natural order. The second is fed the interleaved bits. Every input bit gives one 3-bit output word, registered one cycle after it is accepted. The word holds the systematic bit and the two parity bits.

When the input word flagged as end of block has been taken, both encoders are driven back to the all-zero state in three steps each. The twelve bits this produces are sent as four further output words in a fixed packing. A block of K bits therefore leaves as K+4 words. Both sides are valid/ready streams with start and end markers. A 13-bit size field is read at the start of a block, and the output carries K+4 on its first word.

The control state machine has six states. `ST_IDLE` waits for a start-marked word. `ST_DATA` streams the block. `ST_TAIL0` to `ST_TAIL3` emit the four termination words. Its transitions are:
- idle to data, on accepting a start word;
- data to tail 0, on accepting the end word;
- each tail state to the next, when the output slot frees;
- tail 3 back to idle.

Top module: `turbo_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 while `out_ready` is 1.
- R2: For the data word of index k, bit 0 is X_k. Bit 1 is the parity of the first encoder on the natural bits. Bit 2 is the parity of the second encoder on the interleaved bits. Each encoder starts the block in state zero. Its feedback is u xor s[k-2] xor s[k-3]. Its parity is fb xor s[k-1] xor s[k-3], where s is its feedback history.
- R3: After the data words come four tail words, written as {bit2,bit1,bit0}. They are {X_K+1, Z_K, X_K}, then {Z_K+2, X_K+2, Z_K+1}, then the same two patterns built from the second encoder's X' and Z' tail bits.
- R4: During termination each encoder's input equals its own feedback value, so that each register returns to zero. The second encoder's tail X' bits come from its own state and not from `in_ilv`.
- R5: Each block gives exactly K+4 output words. `out_sop` marks the first word only and `out_eop` the last word only. `out_size` equals K+4 on the first word.
- R6: While `in_valid` is low, the encoding pauses and no word is lost or duplicated.
- R7: While `out_valid` is high and `out_ready` is low, the output word and its markers hold steady. `in_ready` is low whenever the output slot is full and not being drained. Tail words are never lost or repeated under backpressure.
- R8: From the cycle after the end word is accepted until the last tail word is loaded, `in_ready` is low.
- R9: In the idle state, words without `in_sop` are accepted and discarded, and they produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, required before the first block |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_sop | input | 1 | First bit of a block |
| in_eop | input | 1 | Last bit of a block |
| in_sys | input | 1 | Systematic bit X_k |
| in_ilv | input | 1 | Interleaved bit X'_k |
| in_size | input | 13 | Block size K, read with the start word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take the word |
| out_sop | output | 1 | First word of an output block |
| out_eop | output | 1 | Last word of an output block |
| out_data | output | 3 | Coded word {bit2,bit1,bit0} |
| out_size | output | 13 | Output block length K+4, valid with out_sop |

## Verification
The assertions assume that every input block is well formed: it opens with a start marker, has at least two bits, and closes with exactly one end marker. They also assume that `in_size` matches the number of bits actually sent. The stimulus only ever produces such blocks, with sizes from 40 to 6144.

Stray words without a start marker are sent only while the block is idle, and they never carry an end marker. Both the gaps in `in_valid` and the backpressure on `out_ready` are arbitrary. Neither of them is assumed to follow any pattern.

// File: rtl/turbo_enc_pkg.sv
package turbo_enc_pkg;

    localparam int SYM_W      = 3;
    localparam int REG_W      = 3;
    localparam int TAIL_STEPS = 3;
    localparam int TAIL_WORDS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_TAIL0,
        ST_TAIL1,
        ST_TAIL2,
        ST_TAIL3
    } enc_state_e;

    // termination bits of one encoder, index = tail step
    typedef struct packed {
        logic [TAIL_STEPS-1:0] x;
        logic [TAIL_STEPS-1:0] z;
    } tail_t;

    // s[0] newest feedback value, s[2] oldest
    function automatic tail_t flush_bits(input logic [REG_W-1:0] s_in);
        tail_t               t;
        logic [REG_W-1:0]    s;
        s = s_in;
        for (int i = 0; i < TAIL_STEPS; i++) begin
            t.x[i] = s[1] ^ s[2];          // input cancels the feedback
            t.z[i] = s[0] ^ s[2];          // feedback term is zero here
            s      = {s[1], s[0], 1'b0};
        end
        return t;
    endfunction

endpackage

// File: rtl/turbo_rsc_encoder.sv
module turbo_rsc_encoder
    import turbo_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             u,
    output logic             z,
    output logic [REG_W-1:0] st
);

    logic [REG_W-1:0] cur;
    logic             fb;

    always_comb begin
        cur = restart ? '0 : st;
        fb  = u ^ cur[1] ^ cur[2];
        z   = fb ^ cur[0] ^ cur[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= '0;
        else if (en)
            st <= {cur[1], cur[0], fb};
    end

endmodule

// File: rtl/turbo_tail_packer.sv
module turbo_tail_packer
    import turbo_enc_pkg::*;
(
    input  tail_t            tail_a,
    input  tail_t            tail_b,
    input  logic [1:0]       sel,
    output logic [SYM_W-1:0] word
);

    tail_t t;

    always_comb begin
        t = sel[1] ? tail_b : tail_a;
        if (sel[0])
            word = {t.z[2], t.x[2], t.z[1]};
        else
            word = {t.x[1], t.z[0], t.x[0]};
    end

endmodule

// File: rtl/turbo_encoder.sv
module turbo_encoder
    import turbo_enc_pkg::*;
#(
    parameter int SIZE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_sys,
    input  logic              in_ilv,
    input  logic [SIZE_W-1:0] in_size,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [SYM_W-1:0]  out_data,
    output logic [SIZE_W-1:0] out_size
);

    localparam int N_ENC = 2;

    enc_state_e       state, state_nx;
    logic             slot_free;
    logic             accept;
    logic             take_first;
    logic             enc_en;
    logic             in_tail;
    logic [1:0]       tail_sel;
    logic [SYM_W-1:0] tail_word;
    logic [N_ENC-1:0] enc_u;
    logic [N_ENC-1:0] enc_z;
    logic [REG_W-1:0] enc_st [N_ENC];
    tail_t            enc_tail [N_ENC];

    assign slot_free  = !out_valid || out_ready;
    assign in_ready   = slot_free && (state == ST_IDLE || state == ST_DATA);
    assign accept     = in_valid && in_ready;
    assign take_first = accept && (state == ST_IDLE) && in_sop;
    assign enc_en     = take_first || (accept && state == ST_DATA);
    assign enc_u      = {in_ilv, in_sys};

    generate
        for (genvar e = 0; e < N_ENC; e++) begin : g_enc
            turbo_rsc_encoder u_rsc (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (enc_en),
                .restart (take_first),
                .u       (enc_u[e]),
                .z       (enc_z[e]),
                .st      (enc_st[e])
            );
            assign enc_tail[e] = flush_bits(enc_st[e]);
        end
    endgenerate

    turbo_tail_packer u_pack (
        .tail_a (enc_tail[0]),
        .tail_b (enc_tail[1]),
        .sel    (tail_sel),
        .word   (tail_word)
    );

    // next state and tail word selection
    always_comb begin
        state_nx = state;
        in_tail  = 1'b0;
        tail_sel = 2'd0;
        unique case (state)
            ST_IDLE: begin
                if (take_first)
                    state_nx = in_eop ? ST_TAIL0 : ST_DATA;
            end
            ST_DATA: begin
                if (accept && in_eop)
                    state_nx = ST_TAIL0;
            end
            ST_TAIL0: begin
                in_tail  = 1'b1;
                tail_sel = 2'd0;
                if (slot_free) state_nx = ST_TAIL1;
            end
            ST_TAIL1: begin
                in_tail  = 1'b1;
                tail_sel = 2'd1;
                if (slot_free) state_nx = ST_TAIL2;
            end
            ST_TAIL2: begin
                in_tail  = 1'b1;
                tail_sel = 2'd2;
                if (slot_free) state_nx = ST_TAIL3;
            end
            ST_TAIL3: begin
                in_tail  = 1'b1;
                tail_sel = 2'd3;
                if (slot_free) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
            out_size  <= '0;
        end else if (slot_free) begin
            out_valid <= enc_en || in_tail;
            out_sop   <= take_first;
            out_eop   <= (state == ST_TAIL3);
            if (enc_en)
                out_data <= {enc_z[1], enc_z[0], in_sys};
            else if (in_tail)
                out_data <= tail_word;
            if (take_first)
                out_size <= in_size + SIZE_W'(TAIL_WORDS);
        end
    end

endmodule

// File: rtl/turbo_encoder_chk.sv
module turbo_encoder_chk #(
    parameter int SIZE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eop,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_sop,
    input logic              out_eop,
    input logic [2:0]        out_data,
    input logic [SIZE_W-1:0] out_size
);

    logic [SIZE_W:0] word_cnt;
    logic [SIZE_W:0] blk_len;
    logic            out_hs;

    assign out_hs = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_cnt <= '0;
            blk_len  <= '0;
        end else if (out_hs) begin
            if (out_sop) begin
                word_cnt <= 1;
                blk_len  <= {1'b0, out_size};
            end else begin
                word_cnt <= word_cnt + 1'b1;
            end
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_sop) && $stable(out_eop));

    // R7
    in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid || out_ready));

    // R8
    tail_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_eop |=> !in_ready);

    // R5
    marker_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop));

    // R5
    block_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hs && out_eop && !out_sop |-> (word_cnt + 1'b1 == blk_len));

endmodule

bind turbo_encoder turbo_encoder_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data),
    .out_size  (out_size)
);

// File: tb/turbo_encoder_tb.sv
module turbo_encoder_tb;

    localparam int SIZE_W = 13;
    localparam int MAXK   = 6144;
    localparam int LIMIT  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_sop = 1'b0;
    logic              in_eop = 1'b0;
    logic              in_sys = 1'b0;
    logic              in_ilv = 1'b0;
    logic [SIZE_W-1:0] in_size = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic              out_sop;
    logic              out_eop;
    logic [2:0]        out_data;
    logic [SIZE_W-1:0] out_size;

    always #5 clk = ~clk;

    turbo_encoder #(.SIZE_W(SIZE_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_eop(in_eop),
        .in_sys(in_sys), .in_ilv(in_ilv), .in_size(in_size),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sop(out_sop), .out_eop(out_eop),
        .out_data(out_data), .out_size(out_size)
    );

    int  total = 0;
    int  fails = 0;
    int  cyc = 0;
    int  rdy_mode = 0;
    bit  tail_pending = 0;
    bit  xs [MAXK];
    bit  xi [MAXK];
    // entry: tag[11:8] size_flag[7] unused, eop[4] sop[3] data[2:0]
    logic [11:0] exp_q [$];
    int  exp_len_q [$];
    bit  prev_hold = 0;
    logic [4:0] prev_word = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
            summary();
        end
    end

    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            1:       out_ready = ($urandom % 10) < 6;
            2:       out_ready = ($urandom % 4) == 0;
            default: out_ready = 1'b1;
        endcase
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold)
                chk(out_valid && {out_eop, out_sop, out_data} == prev_word, "R7 hold",
                    int'({out_valid, out_eop, out_sop, out_data}), int'({1'b1, prev_word}));
            prev_hold = out_valid && !out_ready;
            prev_word = {out_eop, out_sop, out_data};
            if (out_valid && out_eop) tail_pending = 0;
            if (tail_pending)
                chk(!in_ready, "R8 input blocked during tail", int'(in_ready), 0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected output", int'(out_data), -1);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e[2:0], tag_name(int'(e[11:8])), int'(out_data), int'(e[2:0]));
                    chk({out_eop, out_sop} == e[4:3], "R5 markers",
                        int'({out_eop, out_sop}), int'(e[4:3]));
                    if (e[3]) begin
                        int l;
                        l = exp_len_q.pop_front();
                        chk(int'(out_size) == l, "R5 size", int'(out_size), l);
                    end
                end
            end
        end
    end

    task automatic send_word(input bit sop, input bit eop, input bit x, input bit xp,
                             input int k, input int gap);
        bit got;
        for (int g = 0; g < gap; g++) begin
            in_valid = 1'b0;
            in_sys   = ~x;
            in_ilv   = ~xp;
            @(posedge clk); #1;
        end
        in_valid = 1'b1;
        in_sop   = sop;
        in_eop   = eop;
        in_sys   = x;
        in_ilv   = xp;
        in_size  = SIZE_W'(k);
        got = 0;
        while (!got) begin
            @(negedge clk);
            got = in_valid && in_ready;
            @(posedge clk); #1;
        end
        if (eop) tail_pending = 1;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        in_ilv   = 1'b1;
    endtask

    // reference: feedback history a[k]; fb = u^a[k-2]^a[k-3], par = fb^a[k-1]^a[k-3]
    task automatic push_block(input int k, input int tag);
        int h1 [3];
        int h2 [3];
        int tx1 [3], tz1 [3], tx2 [3], tz2 [3];
        for (int j = 0; j < 3; j++) begin h1[j] = 0; h2[j] = 0; end
        for (int i = 0; i < k; i++) begin
            int f1, f2, p1, p2;
            f1 = xs[i] ^ h1[1] ^ h1[2];
            p1 = f1 ^ h1[0] ^ h1[2];
            f2 = xi[i] ^ h2[1] ^ h2[2];
            p2 = f2 ^ h2[0] ^ h2[2];
            h1[2] = h1[1]; h1[1] = h1[0]; h1[0] = f1;
            h2[2] = h2[1]; h2[1] = h2[0]; h2[0] = f2;
            exp_q.push_back({4'(tag), 3'b0, 1'b0, (i == 0) ? 1'b1 : 1'b0,
                             1'(p2), 1'(p1), 1'(xs[i])});
        end
        for (int t = 0; t < 3; t++) begin
            tx1[t] = h1[1] ^ h1[2];
            tz1[t] = h1[0] ^ h1[2];
            h1[2] = h1[1]; h1[1] = h1[0]; h1[0] = 0;
            tx2[t] = h2[1] ^ h2[2];
            tz2[t] = h2[0] ^ h2[2];
            h2[2] = h2[1]; h2[1] = h2[0]; h2[0] = 0;
        end
        exp_q.push_back({4'd3, 5'b0, 1'(tx1[1]), 1'(tz1[0]), 1'(tx1[0])});
        exp_q.push_back({4'd3, 5'b0, 1'(tz1[2]), 1'(tx1[2]), 1'(tz1[1])});
        exp_q.push_back({4'd4, 5'b0, 1'(tx2[1]), 1'(tz2[0]), 1'(tx2[0])});
        exp_q.push_back({4'd4, 3'b0, 1'b1, 1'b0, 1'(tz2[2]), 1'(tx2[2]), 1'(tz2[1])});
        exp_len_q.push_back(k + 4);
    endtask

    // pmode 0 random, 1 all zero, 2 all one
    task automatic send_block(input int k, input int pmode, input int gapmode, input int tag);
        for (int i = 0; i < k; i++) begin
            xs[i] = (pmode == 0) ? 1'($urandom) : (pmode == 2);
            xi[i] = (pmode == 0) ? 1'($urandom) : (pmode == 2);
        end
        push_block(k, tag);
        for (int i = 0; i < k; i++)
            send_word(i == 0, i == k - 1, xs[i], xi[i], k,
                      gapmode ? int'($urandom % 3) : 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || out_valid) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
        @(posedge clk); #1;

        rdy_mode = 0; send_block(40, 0, 0, 2);   drain();    // R2 R3 R4
        rdy_mode = 0; send_block(48, 1, 0, 2);   drain();
        rdy_mode = 0; send_block(52, 2, 0, 2);   drain();
        rdy_mode = 1; send_block(40, 0, 0, 7);   drain();    // R7
        rdy_mode = 2; send_block(61, 0, 0, 7);   drain();
        rdy_mode = 0; send_block(57, 0, 1, 6);   drain();    // R6
        rdy_mode = 1; send_block(100, 0, 1, 6);  drain();

        // R9: stray words while idle
        rdy_mode = 0;
        for (int g = 0; g < 3; g++) send_word(1'b0, 1'b0, 1'b1, 1'b1, 40, 0);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(!out_valid, "R9 stray word output", int'(out_valid), 0);
        end
        @(posedge clk); #1;
        send_block(40, 0, 0, 2); drain();

        // back-to-back blocks, no drain between
        rdy_mode = 1;
        send_block(44, 0, 0, 2);
        send_block(40, 2, 1, 2);
        drain();

        // largest block
        rdy_mode = 1; send_block(6144, 0, 0, 2); drain();

        repeat (4) @(posedge clk);
        chk(exp_len_q.size() == 0, "R5 all blocks closed", exp_len_q.size(), 0);
        summary();
    end

endmodule